// File: doc/BRIEF.md
# Seven-Segment Decoder Bank Signature Self-Test

This block tests a bank of four built-in BCD-to-seven-segment decoders without any external pattern source. A 4-bit shift register with feedback produces the stimulus from a seed. Each cycle it is stepped, its value drives the four decoders, and the 28 segment outputs are folded into a 28-bit multiple-input signature register.

At the end of a session a compare strobe checks the signature against a golden value. That value is computed at elaboration for the sequence that starts from the reset seed and runs for `RUN_LEN` steps. The result is held on a single fault flag. A fault-injection input pins one segment bit to a constant, so the pass/fail path itself can be exercised.

A session runs in three steps. First, pulse the seed load, which also clears the signature. Then hold both enables for `RUN_LEN` cycles. Finally, pulse the compare strobe.

Top module: `segsig_selftest`

## Requirements
- R1: While `rst_n` is low, `pattern` is `RESET_SEED` (default 4'b0001), `signature` is zero and `fault` is 0.
- R2: A cycle with `seed_load` high sets `pattern` to `seed_in` and clears `signature` to zero at that edge. `seed_load` takes priority over both enables.
- R3: A load with `seed_in` equal to zero sets `pattern` to 4'b0001, so the all-zero state is never entered.
- R4: Each edge with `lfsr_en` high and no load advances `pattern` to `{pattern[2:0], pattern[3]^pattern[2]^pattern[0]}`, which is the polynomial 1+x+x^3+x^4. With `lfsr_en` low, `pattern` holds.
- R5: Because the polynomial is not primitive, the sequence from 4'b0001 repeats after 6 steps: 1, 3, 7, 14, 12, 8.
- R6: Digit k (k = 0..3) decodes `pattern` rotated left by k bits. Its segments appear on `seg_out[7k+6:7k]` as {g,f,e,d,c,b,a}, active high. The codes for values 0 to 9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex). Values 10 to 15 give 00. `seg_out` follows `pattern` in the same cycle.
- R7: Each edge with `misr_en` high and no load sets `signature` to `((signature << 1) ^ (signature[27] ? 28'h0000009 : 0)) ^ seg_out`. With `misr_en` low, `signature` holds.
- R8: On an edge with `cmp_strobe` high, `fault` becomes 1 if `signature` differs from the golden value and 0 if it matches. At all other edges `fault` holds.
- R9: While `fault_inj` is high, `seg_out[INJ_BIT]` reads `INJ_VAL` (default bit 0, value 0). This is segment a of digit 0, and the forced value also enters the signature.
- R10: A seed load of 4'b0001 followed by `RUN_LEN` (default 12) cycles with both enables high, with no injection, and then a compare gives `fault` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| seed_load | input | 1 | Load `seed_in` and clear the signature |
| seed_in | input | 4 | Seed value |
| lfsr_en | input | 1 | Advance the pattern generator |
| misr_en | input | 1 | Fold the decoder outputs into the signature |
| cmp_strobe | input | 1 | Compare the signature with the golden value |
| fault_inj | input | 1 | Force one segment bit to a constant |
| pattern | output | 4 | Current stimulus value |
| seg_out | output | 28 | Decoder bank outputs, four digits of 7 bits |
| signature | output | 28 | Signature register |
| fault | output | 1 | Registered pass/fail result, 1 = mismatch |

## Verification
`seg_out` is combinational from `pattern`, so it is read in the same cycle the pattern is held. `pattern` and `signature` move one edge after a load or an enabled cycle, and `fault` moves one edge after the strobe. The bench drives inputs on the falling edge and samples on the next falling edge, which is half a period after the single register edge that applies. A reference model in the bench steps the generator and the signature once per enabled edge, so every expected value lines up with that single edge of delay.

// File: rtl/segsig_selftest.sv
module segsig_selftest #(
  parameter logic [3:0]  RESET_SEED = 4'b0001,
  parameter int          RUN_LEN    = 12,
  parameter int          INJ_BIT    = 0,
  parameter bit          INJ_VAL    = 1'b0,
  parameter logic [27:0] MISR_TAPS  = 28'h0000009
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        seed_load,
  input  logic [3:0]  seed_in,
  input  logic        lfsr_en,
  input  logic        misr_en,
  input  logic        cmp_strobe,
  input  logic        fault_inj,
  output logic [3:0]  pattern,
  output logic [27:0] seg_out,
  output logic [27:0] signature,
  output logic        fault
);
  localparam int DIGITS = 4;
  localparam int SEGS   = 7;
  localparam int RW     = DIGITS * SEGS;

  function automatic logic [6:0] seg7(input logic [3:0] d);
    case (d)
      4'd0: seg7 = 7'h3F;
      4'd1: seg7 = 7'h06;
      4'd2: seg7 = 7'h5B;
      4'd3: seg7 = 7'h4F;
      4'd4: seg7 = 7'h66;
      4'd5: seg7 = 7'h6D;
      4'd6: seg7 = 7'h7D;
      4'd7: seg7 = 7'h07;
      4'd8: seg7 = 7'h7F;
      4'd9: seg7 = 7'h6F;
      default: seg7 = 7'h00;
    endcase
  endfunction

  function automatic logic [3:0] rotl(input logic [3:0] p, input int k);
    logic [7:0] dbl;
    dbl  = {p, p} << k;
    rotl = dbl[7:4];
  endfunction

  function automatic logic [3:0] lfsr_step(input logic [3:0] p);
    lfsr_step = {p[2:0], p[3] ^ p[2] ^ p[0]};
  endfunction

  function automatic logic [RW-1:0] bank(input logic [3:0] p);
    for (int k = 0; k < DIGITS; k++)
      bank[k*SEGS +: SEGS] = seg7(rotl(p, k));
  endfunction

  function automatic logic [RW-1:0] misr_step(input logic [RW-1:0] m, input logic [RW-1:0] r);
    misr_step = ((m << 1) ^ (m[RW-1] ? MISR_TAPS : '0)) ^ r;
  endfunction

  function automatic logic [RW-1:0] calc_golden();
    logic [3:0]    p;
    logic [RW-1:0] m;
    p = RESET_SEED;
    m = '0;
    for (int i = 0; i < RUN_LEN; i++) begin
      m = misr_step(m, bank(p));
      p = lfsr_step(p);
    end
    calc_golden = m;
  endfunction

  localparam logic [RW-1:0] GOLDEN = calc_golden();

  logic [RW-1:0] raw_seg;

  for (genvar k = 0; k < DIGITS; k++) begin : g_dig
    assign raw_seg[k*SEGS +: SEGS] = seg7(rotl(pattern, k));
  end

  always_comb begin
    seg_out = raw_seg;
    if (fault_inj) seg_out[INJ_BIT] = INJ_VAL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pattern   <= RESET_SEED;
      signature <= '0;
    end else if (seed_load) begin
      pattern   <= (seed_in == 4'd0) ? 4'd1 : seed_in;
      signature <= '0;
    end else begin
      if (lfsr_en) pattern   <= lfsr_step(pattern);
      if (misr_en) signature <= misr_step(signature, seg_out);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          fault <= 1'b0;
    else if (cmp_strobe) fault <= (signature != GOLDEN);
  end
endmodule

module segsig_selftest_chk #(
  parameter int INJ_BIT = 0,
  parameter bit INJ_VAL = 1'b0
) (
  input logic        clk,
  input logic        rst_n,
  input logic        seed_load,
  input logic [3:0]  seed_in,
  input logic        lfsr_en,
  input logic        misr_en,
  input logic        cmp_strobe,
  input logic        fault_inj,
  input logic [3:0]  pattern,
  input logic [27:0] seg_out,
  input logic [27:0] signature,
  input logic        fault
);
  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    seed_load && seed_in != 4'd0 |=> pattern == $past(seed_in) && signature == '0);

  a_r3_zero_seed: assert property (@(posedge clk) disable iff (!rst_n)
    seed_load && seed_in == 4'd0 |=> pattern == 4'd1);

  a_r3_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
    pattern != 4'd0);

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !seed_load && !lfsr_en |=> $stable(pattern));

  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    !seed_load && lfsr_en |=> pattern[3:1] == $past(pattern[2:0]));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !seed_load && !misr_en |=> $stable(signature));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_strobe |=> $stable(fault));

  a_r9_inject: assert property (@(posedge clk) disable iff (!rst_n)
    fault_inj |-> seg_out[INJ_BIT] == INJ_VAL);
endmodule

bind segsig_selftest segsig_selftest_chk #(.INJ_BIT(INJ_BIT), .INJ_VAL(INJ_VAL)) u_chk (.*);

// File: tb/sim_segsig_selftest.sv
module sim_segsig_selftest;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        seed_load = 1'b0;
  logic [3:0]  seed_in = 4'd0;
  logic        lfsr_en = 1'b0;
  logic        misr_en = 1'b0;
  logic        cmp_strobe = 1'b0;
  logic        fault_inj = 1'b0;
  logic [3:0]  pattern;
  logic [27:0] seg_out;
  logic [27:0] signature;
  logic        fault;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  segsig_selftest u0 (.*);

  function automatic logic [6:0] m_seg(input logic [3:0] d);
    logic [6:0] t [10] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07, 7'h7F, 7'h6F};
    m_seg = (d < 4'd10) ? t[d] : 7'h00;
  endfunction

  function automatic logic [27:0] m_bank(input logic [3:0] p, input bit inj);
    logic [3:0] r;
    r = p;
    for (int k = 0; k < 4; k++) begin
      m_bank[7*k +: 7] = m_seg(r);
      r = {r[2:0], r[3]};
    end
    if (inj) m_bank[0] = 1'b0;
  endfunction

  function automatic logic [3:0] m_next(input logic [3:0] p);
    m_next = {p[2:0], p[3] ^ p[2] ^ p[0]};
  endfunction

  function automatic logic [27:0] m_misr(input logic [27:0] m, input logic [27:0] r);
    m_misr = {m[26:0], 1'b0} ^ (m[27] ? 28'h0000009 : 28'h0) ^ r;
  endfunction

  function automatic logic [27:0] m_run(input logic [3:0] s, input int n, input bit inj);
    logic [3:0]  p;
    logic [27:0] m;
    p = (s == 4'd0) ? 4'd1 : s;
    m = '0;
    for (int i = 0; i < n; i++) begin
      m = m_misr(m, m_bank(p, inj));
      p = m_next(p);
    end
    m_run = m;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input bit ld, input logic [3:0] sd, input bit le, input bit me, input bit cs);
    seed_load = ld; seed_in = sd; lfsr_en = le; misr_en = me; cmp_strobe = cs;
    @(negedge clk);
    seed_load = 0; lfsr_en = 0; misr_en = 0; cmp_strobe = 0;
  endtask

  // {seed, steps, misr on}
  localparam logic [12:0] VEC [7] = '{
    {4'd1,  8'd12, 1'b1},
    {4'd1,  8'd11, 1'b1},
    {4'd2,  8'd12, 1'b1},
    {4'd9,  8'd5,  1'b1},
    {4'd0,  8'd12, 1'b1},
    {4'd15, 8'd3,  1'b0},
    {4'd6,  8'd20, 1'b1}
  };

  logic [27:0] gold;

  initial begin
    gold = m_run(4'd1, 12, 0);
    @(negedge clk);
    chk("R1 pattern", pattern, 4'd1);
    chk("R1 signature", signature, 0);
    chk("R1 fault", fault, 0);
    chk("R6 seg at reset", seg_out, m_bank(4'd1, 0));
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < 7; v++) begin
      logic [3:0]  s, p;
      logic [27:0] m;
      int          n;
      s = VEC[v][12:9]; n = int'(VEC[v][8:1]);
      p = (s == 4'd0) ? 4'd1 : s;
      m = '0;
      cyc(1, s, 1, 1, 0);
      chk("R2/R3 load pattern", pattern, p);
      chk("R2 load clears signature", signature, 0);
      for (int i = 0; i < n; i++) begin
        chk("R6 seg_out", seg_out, m_bank(p, 0));
        cyc(0, 0, 1, VEC[v][0], 0);
        if (VEC[v][0]) m = m_misr(m, m_bank(p, 0));
        p = m_next(p);
      end
      chk("R4 pattern after run", pattern, p);
      chk("R7 signature after run", signature, m);
      cyc(0, 0, 0, 0, 1);
      chk("R8/R10 fault", fault, (m != gold));
    end

    for (int d = 1; d < 16; d++) begin
      cyc(1, 4'(d), 0, 0, 0);
      chk("R6 decode", seg_out, m_bank(4'(d), 0));
    end

    cyc(1, 4'd1, 0, 0, 0);
    begin
      logic [3:0] e [6] = '{4'd3, 4'd7, 4'd14, 4'd12, 4'd8, 4'd1};
      for (int i = 0; i < 6; i++) begin
        cyc(0, 0, 1, 0, 0);
        chk("R5 sequence", pattern, e[i]);
      end
    end
    chk("R7 hold with misr_en low", signature, 0);

    cyc(1, 4'd3, 0, 0, 0);
    chk("R9 bit clear without inj", seg_out[0], 1'b1);
    fault_inj = 1'b1;
    #1;
    chk("R9 bit forced", seg_out[0], 1'b0);
    cyc(1, 4'd1, 0, 0, 0);
    for (int i = 0; i < 12; i++) cyc(0, 0, 1, 1, 0);
    chk("R9 injected signature", signature, m_run(4'd1, 12, 1));
    cyc(0, 0, 0, 0, 1);
    chk("R9 fault raised", fault, 1'b1);
    fault_inj = 1'b0;
    cyc(0, 0, 1, 1, 0);
    chk("R8 fault holds without strobe", fault, 1'b1);

    cyc(1, 4'd1, 0, 0, 0);
    for (int i = 0; i < 12; i++) cyc(0, 0, 1, 1, 0);
    cyc(0, 0, 0, 0, 1);
    chk("R10 golden pass", fault, 1'b0);

    cyc(1, 4'd5, 0, 1, 0);
    cyc(1, 4'd1, 1, 1, 0);
    chk("R2 load priority pattern", pattern, 4'd1);
    chk("R2 load priority signature", signature, 0);

    rst_n = 1'b0;
    #1;
    chk("R1 async reset pattern", pattern, 4'd1);
    chk("R1 async reset fault", fault, 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule